// File: doc/BRIEF.md
# Two-Way Doorbell Interrupt Registers

This block lets a local processor and a remote host on a shared bus signal each other. It holds two 32-bit doorbell registers. The inbound register is the remote host's way to interrupt the local side. The remote side rings it by writing ones, which set the addressed bits. The local side acknowledges by writing ones, which clear those bits. While any inbound bit is set, a level interrupt request goes to the local interrupt controller.

The outbound register works the same way in the other direction. The local side sets its bits, and the remote side clears them. While any outbound bit is set, an active-low interrupt line to the remote host is held low.

Each side has a simple register port: a write strobe, a one-bit register select, write data and read data. Each side can read both registers, and reads change nothing. The bus protocols, the interrupt controller, and any masking or priority are outside this block.

Top module: `doorbell_pair`

## Requirements
- R1: A remote write with select 0 (inbound) sets every inbound bit whose write-data bit is 1. The other inbound bits are unchanged. The new value is visible one clock after the write.
- R2: A local write with select 0 clears every inbound bit whose write-data bit is 1. Bits written with 0 keep their value.
- R3: `loc_irq` is 1 exactly when at least one inbound bit is 1. It comes from a flop and changes in the same cycle as the inbound register.
- R4: A local write with select 1 (outbound) sets every outbound bit whose write-data bit is 1. The other outbound bits are unchanged.
- R5: A remote write with select 1 clears every outbound bit whose write-data bit is 1. Bits written with 0 keep their value.
- R6: `rem_irq_n` is 0 exactly when at least one outbound bit is 1. It comes from a flop and changes in the same cycle as the outbound register.
- R7: When a set and a clear reach the same bit in the same cycle, the bit ends up 1. A clear of other bits in that same cycle still takes effect.
- R8: On each side, read data shows the inbound register when that side's select is 0 and the outbound register when it is 1. The read path is combinational, and reading changes no state.
- R9: A synchronous active-high `rst` clears both registers, drives `loc_irq` to 0 and drives `rem_irq_n` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| loc_wr | input | 1 | Local-side write strobe |
| loc_sel | input | 1 | Local register select: 0 = inbound, 1 = outbound |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data |
| rem_wr | input | 1 | Remote-side write strobe |
| rem_sel | input | 1 | Remote register select: 0 = inbound, 1 = outbound |
| rem_wdata | input | 32 | Remote write data |
| rem_rdata | output | 32 | Remote read data |
| loc_irq | output | 1 | Interrupt request to the local controller, active high |
| rem_irq_n | output | 1 | Interrupt line to the remote host, active low |

## Verification
Two functions can meet in one cycle: a ring from one side and an acknowledge from the other, aimed at the same register.

The bench provokes this by driving both ports in one clock, once on the inbound register and once on the outbound register. In each case the write data overlaps on some bits and differs on others.

It judges the result with a reference value computed as (old AND NOT clear) OR set. Overlapping bits must survive, and cleared bits that were not also set must drop. The interrupt pin must agree with the result in that same cycle.

// File: rtl/db_pkg.sv
package db_pkg;
    typedef enum logic {
        DB_SEL_IN  = 1'b0,
        DB_SEL_OUT = 1'b1
    } db_sel_e;

    localparam int DB_NUM_REGS = 2;
    localparam int DB_IDX_IN   = 0;
    localparam int DB_IDX_OUT  = 1;
endpackage

// File: rtl/db_side_dec.sv
module db_side_dec #(
    parameter int W = 32
) (
    input  logic         wr,
    input  logic         sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] in_mask,
    output logic [W-1:0] out_mask
);
    import db_pkg::*;

    db_sel_e sel_e;

    always_comb begin
        sel_e    = db_sel_e'(sel);
        in_mask  = '0;
        out_mask = '0;
        if (wr) begin
            if (sel_e == DB_SEL_IN) begin
                in_mask = wdata;
            end else begin
                out_mask = wdata;
            end
        end
    end
endmodule

// File: rtl/db_rd_mux.sv
module db_rd_mux #(
    parameter int W = 32
) (
    input  logic         sel,
    input  logic [W-1:0] in_bits,
    input  logic [W-1:0] out_bits,
    output logic [W-1:0] rdata
);
    import db_pkg::*;

    always_comb begin
        unique case (db_sel_e'(sel))
            DB_SEL_IN:  rdata = in_bits;
            DB_SEL_OUT: rdata = out_bits;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/db_reg.sv
module db_reg #(
    parameter int W          = 32,
    parameter bit ACTIVE_LOW = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_mask,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] bits,
    output logic         irq
);
    localparam logic IRQ_IDLE = ACTIVE_LOW;

    typedef struct packed {
        logic [W-1:0] bits;
        logic         irq;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr_mask) | set_mask;
        st_d.irq  = (|st_d.bits) ? ~IRQ_IDLE : IRQ_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.bits <= '0;
            st_q.irq  <= IRQ_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits = st_q.bits;
    assign irq  = st_q.irq;

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        (set_mask != '0) |=> ((st_q.bits & $past(set_mask)) == $past(set_mask))); // R7

    AST_CLR_LANDS: assert property (@(posedge clk) disable iff (rst)
        ((clr_mask & ~set_mask) != '0) |=> ((st_q.bits & $past(clr_mask & ~set_mask)) == '0)); // R2

    AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((($past(st_q.bits) ^ st_q.bits) & ~$past(set_mask | clr_mask)) == '0)); // R1

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (st_q.irq == ((|st_q.bits) ? ~IRQ_IDLE : IRQ_IDLE))); // R3

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (st_q.bits == '0 && st_q.irq == IRQ_IDLE)); // R9
endmodule

// File: rtl/doorbell_pair.sv
module doorbell_pair #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         loc_wr,
    input  logic         loc_sel,
    input  logic [W-1:0] loc_wdata,
    output logic [W-1:0] loc_rdata,
    input  logic         rem_wr,
    input  logic         rem_sel,
    input  logic [W-1:0] rem_wdata,
    output logic [W-1:0] rem_rdata,
    output logic         loc_irq,
    output logic         rem_irq_n
);
    import db_pkg::*;

    logic [W-1:0] loc_in_m, loc_out_m, rem_in_m, rem_out_m;
    logic [W-1:0] set_m [DB_NUM_REGS];
    logic [W-1:0] clr_m [DB_NUM_REGS];
    logic [W-1:0] val   [DB_NUM_REGS];
    logic         irq_w [DB_NUM_REGS];

    db_side_dec #(.W(W)) u_loc_dec (
        .wr(loc_wr), .sel(loc_sel), .wdata(loc_wdata),
        .in_mask(loc_in_m), .out_mask(loc_out_m)
    );

    db_side_dec #(.W(W)) u_rem_dec (
        .wr(rem_wr), .sel(rem_sel), .wdata(rem_wdata),
        .in_mask(rem_in_m), .out_mask(rem_out_m)
    );

    // Inbound: remote rings, local acknowledges. Outbound: the reverse.
    always_comb begin
        set_m[DB_IDX_IN]  = rem_in_m;
        clr_m[DB_IDX_IN]  = loc_in_m;
        set_m[DB_IDX_OUT] = loc_out_m;
        clr_m[DB_IDX_OUT] = rem_out_m;
    end

    for (genvar g = 0; g < DB_NUM_REGS; g++) begin : g_reg
        db_reg #(.W(W), .ACTIVE_LOW(g == DB_IDX_OUT)) u_reg (
            .clk(clk), .rst(rst),
            .set_mask(set_m[g]), .clr_mask(clr_m[g]),
            .bits(val[g]), .irq(irq_w[g])
        );
    end

    db_rd_mux #(.W(W)) u_loc_rd (
        .sel(loc_sel), .in_bits(val[DB_IDX_IN]), .out_bits(val[DB_IDX_OUT]),
        .rdata(loc_rdata)
    );

    db_rd_mux #(.W(W)) u_rem_rd (
        .sel(rem_sel), .in_bits(val[DB_IDX_IN]), .out_bits(val[DB_IDX_OUT]),
        .rdata(rem_rdata)
    );

    assign loc_irq   = irq_w[DB_IDX_IN];
    assign rem_irq_n = irq_w[DB_IDX_OUT];

    AST_LOC_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (loc_irq == (|val[DB_IDX_IN]))); // R3

    AST_REM_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (rem_irq_n == ~(|val[DB_IDX_OUT]))); // R6

    AST_REM_RING_IN: assert property (@(posedge clk) disable iff (rst)
        (rem_wr && !rem_sel) |=> ((val[DB_IDX_IN] & $past(rem_wdata)) == $past(rem_wdata))); // R1

    AST_LOC_RING_OUT: assert property (@(posedge clk) disable iff (rst)
        (loc_wr && loc_sel) |=> ((val[DB_IDX_OUT] & $past(loc_wdata)) == $past(loc_wdata))); // R4

    AST_REM_ACK_OUT: assert property (@(posedge clk) disable iff (rst)
        (rem_wr && rem_sel && !(loc_wr && loc_sel)) |=> ((val[DB_IDX_OUT] & $past(rem_wdata)) == '0)); // R5
endmodule

// File: tb/sim_doorbell_pair.sv
module sim_doorbell_pair;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         loc_wr = 1'b0, loc_sel = 1'b0;
    logic [W-1:0] loc_wdata = '0;
    logic         rem_wr = 1'b0, rem_sel = 1'b0;
    logic [W-1:0] rem_wdata = '0;
    logic [W-1:0] loc_rdata, rem_rdata;
    logic         loc_irq, rem_irq_n;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_in  = '0;
    logic [W-1:0] exp_out = '0;

    always #10 clk = ~clk;

    doorbell_pair #(.W(W)) u0 (
        .clk(clk), .rst(rst),
        .loc_wr(loc_wr), .loc_sel(loc_sel), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .rem_wr(rem_wr), .rem_sel(rem_sel), .rem_wdata(rem_wdata), .rem_rdata(rem_rdata),
        .loc_irq(loc_irq), .rem_irq_n(rem_irq_n)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Registers are read on both ports, the interrupt pins are compared
    // against the model; called at a negedge.
    task automatic check_all(input string req);
        loc_sel = 1'b0; rem_sel = 1'b1;
        #1;
        check({req, " loc reads inbound R8"},  loc_rdata, exp_in);
        check({req, " rem reads outbound R8"}, rem_rdata, exp_out);
        loc_sel = 1'b1; rem_sel = 1'b0;
        #1;
        check({req, " loc reads outbound R8"}, loc_rdata, exp_out);
        check({req, " rem reads inbound R8"},  rem_rdata, exp_in);
        check({req, " loc_irq R3"},   {31'b0, loc_irq},   {31'b0, |exp_in});
        check({req, " rem_irq_n R6"}, {31'b0, rem_irq_n}, {31'b0, ~(|exp_out)});
    endtask

    // One clock of writes on either or both ports; model updated per R1,R2,R4,R5,R7.
    task automatic cycle_wr(input logic lw, input logic ls, input logic [W-1:0] ld,
                            input logic rw, input logic rs, input logic [W-1:0] rd);
        logic [W-1:0] in_set, in_clr, out_set, out_clr;
        in_set  = (rw && !rs) ? rd : '0;
        in_clr  = (lw && !ls) ? ld : '0;
        out_set = (lw &&  ls) ? ld : '0;
        out_clr = (rw &&  rs) ? rd : '0;
        loc_wr = lw; loc_sel = ls; loc_wdata = ld;
        rem_wr = rw; rem_sel = rs; rem_wdata = rd;
        @(posedge clk);
        exp_in  = (exp_in  & ~in_clr)  | in_set;
        exp_out = (exp_out & ~out_clr) | out_set;
        @(negedge clk);
        loc_wr = 1'b0; rem_wr = 1'b0; loc_wdata = '0; rem_wdata = '0;
    endtask

    task automatic t_reset_state();
        check_all("reset R9");
    endtask

    task automatic t_inbound();
        cycle_wr(0, 0, '0, 1, 0, 32'h0000_0005);
        check_all("inbound ring R1");
        cycle_wr(0, 0, '0, 1, 0, 32'h8000_0000);
        check_all("inbound ring keeps R1");
        cycle_wr(1, 0, 32'h0000_0004, 0, 0, '0);
        check_all("inbound ack R2");
        cycle_wr(1, 0, 32'h0000_0000, 0, 0, '0);
        check_all("inbound zero write R2");
        cycle_wr(1, 0, 32'h8000_0001, 0, 0, '0);
        check_all("inbound all acked R2 R3");
    endtask

    task automatic t_outbound();
        cycle_wr(1, 1, 32'h0001_0100, 0, 0, '0);
        check_all("outbound ring R4");
        cycle_wr(0, 0, '0, 1, 1, 32'h0000_0100);
        check_all("outbound ack R5");
        cycle_wr(0, 0, '0, 1, 1, 32'h0000_0000);
        check_all("outbound zero write R5");
        cycle_wr(0, 0, '0, 1, 1, 32'hFFFF_FFFF);
        check_all("outbound all acked R5 R6");
    endtask

    task automatic t_collision();
        cycle_wr(0, 0, '0, 1, 0, 32'h0000_00F0);
        cycle_wr(1, 0, 32'h0000_0030, 1, 0, 32'h0000_0011);
        check({"collision inbound set wins R7"}, exp_in, 32'h0000_00D1);
        check_all("collision inbound R7");
        cycle_wr(1, 1, 32'h0000_0A00, 0, 0, '0);
        cycle_wr(1, 1, 32'h0000_0300, 1, 1, 32'h0000_0F00);
        check_all("collision outbound R7");
        cycle_wr(1, 0, 32'h0000_0F0F, 1, 1, 32'h0000_0C00);
        check_all("both sides different regs R2 R5");
    endtask

    task automatic t_read_no_effect();
        for (int i = 0; i < 4; i++) begin
            loc_sel = i[0]; rem_sel = i[1];
            @(negedge clk);
        end
        check_all("reads leave state R8");
    endtask

    task automatic t_reset_midrun();
        cycle_wr(1, 1, 32'h1234_5678, 1, 0, 32'h0F0F_0000);
        check_all("pre-reset load R1 R4");
        rst = 1'b1;
        @(posedge clk);
        exp_in = '0; exp_out = '0;
        @(negedge clk);
        rst = 1'b0;
        check_all("mid-run reset R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_inbound();
        t_outbound();
        t_collision();
        t_read_no_effect();
        t_reset_midrun();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule